// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio and emits one single-cycle pulse, `fb_pulse`, per completed division cycle. The pulse goes to a phase comparator. The ratio is built the pulse-swallow way. A dual-modulus prescaler counts the input clock. A swallow counter keeps the prescaler on its long modulus (P+1) for the first A prescaler periods, and it uses the short modulus P after that. A main counter counts prescaler periods and closes the cycle after N of them. The total ratio is N·P + A input clocks. One select pin picks the modulus pair: 32/33 or 64/65.

Settings are taken from the input pins at two moments: at every cycle boundary, and on every clock while the block is parked. The block is parked while reset is low or while the active-low run pin is low (power save). When the run pin goes high, both counters start from the values they took while parked.

The block carries no data stream. All of its pins are plain control and status lines, so no valid/ready handshake and no back-pressure rules apply. A settings error flag warns when the swallow count is larger than the main count, a case the method cannot divide correctly.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` is 0. Reset parks the block in the same way as power save, so R6 timing also holds counted from the first clock edge after `rst_n` rises.
- R2: With `pair_sel`=0 (32/33 pair, P=32), successive `fb_pulse` pulses are exactly N·32 + A input clock edges apart.
- R3: With `pair_sel`=1 (64/65 pair, P=64), successive `fb_pulse` pulses are exactly N·64 + A input clock edges apart.
- R4: The prescaler runs P+1 clocks per period for the first A periods of a cycle and P clocks for the remaining N−A periods. With A=0 the ratio is exactly N·P, and with A=N it is N·(P+1).
- R5: While `run_n` is low, `fb_pulse` stays 0 for any length of time, including spans longer than one full division cycle.
- R6: `run_n` is sampled at the rising edge of `clk_in`. Counting the first rising edge at which `run_n` is high as edge 1, the first `fb_pulse` is high after edge N·P + A. Its values come from the settings present while the block was parked.
- R7: `fb_pulse` is high for exactly one input clock cycle.
- R8: A change of `swallow_val`, `main_val` or `pair_sel` during a division cycle does not alter that cycle. The new values take effect from the next cycle boundary.
- R9: `cfg_err` is 1 whenever `swallow_val` > `main_val`, and 0 otherwise. It follows the pins combinationally.
- R10: The counter extremes divide correctly: N=2047 with A=127 on the 32/33 pair gives 65631, and N=3 with A=0 on the 32/33 pair gives 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided (prescaler input) |
| rst_n | input | 1 | Synchronous active-low reset; parks the divider |
| run_n | input | 1 | Active-low enable: 0 = power save (parked), 1 = dividing |
| swallow_val | input | 7 | Swallow count A, 0 to 127 |
| main_val | input | 11 | Main count N, 3 to 2047 |
| pair_sel | input | 1 | Modulus pair: 0 = 32/33, 1 = 64/65 |
| fb_pulse | output | 1 | Divided output pulse, one clock wide per division cycle |
| cfg_err | output | 1 | High when swallow count exceeds main count |

## Verification
The embedded properties check four things on every cycle:
- the divided pulse is never wider than one clock;
- it stays low in the cycle after a parked clock;
- the prescaler is reloaded only with P or P−1 of one of the two pairs;
- once the swallow count is spent, it stays spent until the cycle boundary.

The exact ratio N·P + A can only be shown by the bench's directed scenarios, which count clock edges between pulses for both pairs and at the counter extremes. The same holds for the restart timing after power save or reset, for the rule that mid-cycle setting changes wait for the next boundary, and for the settings error flag.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic {
    PAIR_32_33 = 1'b0,
    PAIR_64_65 = 1'b1
  } pair_e;
endpackage

// File: rtl/swd_prescaler.sv
// Dual-modulus prescaler: counts the input clock down and ticks once per
// period. Reload value picks P or P+1 of the selected pair.
module swd_prescaler
  import swd_pkg::*;
#(
  parameter int P_LO = 32,
  parameter int P_HI = 64,
  localparam int PC_W = $clog2(P_HI + 2)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  pair_e pair,
  input  logic  long_next,
  output logic  tick
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] reload;

  always_comb begin
    if (pair == PAIR_64_65)
      reload = long_next ? PC_W'(P_HI) : PC_W'(P_HI - 1);
    else
      reload = long_next ? PC_W'(P_LO) : PC_W'(P_LO - 1);
  end

  assign tick = !hold && (pc == '0);

  always_ff @(posedge clk) begin
    if (hold || tick) pc <= reload;
    else              pc <= pc - PC_W'(1);
  end

  // R4: each period starts from P or P-1 of one of the two pairs
  assert_modulus_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pc == PC_W'(P_LO) || pc == PC_W'(P_LO - 1) ||
              pc == PC_W'(P_HI) || pc == PC_W'(P_HI - 1)));
endmodule

// File: rtl/swd_cycle_ctl.sv
// Swallow and main counters; close the division cycle and emit the pulse.
module swd_cycle_ctl #(
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           tick,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  output logic           long_next,
  output logic           boundary,
  output logic           fp
);
  logic [A_W-1:0] a_rem, a_nx;
  logic [N_W-1:0] n_rem, n_nx;

  always_comb begin
    boundary = tick && (n_rem == N_W'(1));
    if (hold || boundary) begin
      a_nx = a_in;
      n_nx = n_in;
    end else if (tick) begin
      a_nx = (a_rem != '0) ? a_rem - A_W'(1) : a_rem;
      n_nx = n_rem - N_W'(1);
    end else begin
      a_nx = a_rem;
      n_nx = n_rem;
    end
    long_next = (a_nx != '0);
  end

  always_ff @(posedge clk) begin
    a_rem <= a_nx;
    n_rem <= n_nx;
    fp    <= !hold && boundary;
  end

  // R7: the divided pulse is one clock wide
  assert_fp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> !fp);

  // R5: a parked clock never produces a pulse
  assert_save_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !fp);

  // R4: once the swallow phase is over it stays over until the boundary
  assert_swallow_spent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && tick && a_rem == '0 && n_rem != N_W'(1)) |=> (a_rem == '0));
endmodule

// File: rtl/swd_cfg_hold.sv
// Holds the modulus pair for a whole division cycle; flags bad settings.
module swd_cfg_hold
  import swd_pkg::*;
#(
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input  logic           clk,
  input  logic           take,
  input  pair_e          pair_in,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  output pair_e          pair_eff,
  output logic           cfg_err
);
  localparam int CW = (A_W > N_W) ? A_W : N_W;
  pair_e pair_q;

  always_ff @(posedge clk) begin
    if (take) pair_q <= pair_in;
  end

  assign pair_eff = take ? pair_in : pair_q;
  assign cfg_err  = CW'(a_in) > CW'(n_in);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swd_pkg::*;
#(
  parameter int A_W  = 7,
  parameter int N_W  = 11,
  parameter int P_LO = 32,
  parameter int P_HI = 64
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic           run_n,
  input  logic [A_W-1:0] swallow_val,
  input  logic [N_W-1:0] main_val,
  input  logic           pair_sel,
  output logic           fb_pulse,
  output logic           cfg_err
);
  logic  hold, tick, long_next, boundary;
  pair_e pair_eff;

  assign hold = !rst_n || !run_n;

  swd_cfg_hold #(.A_W(A_W), .N_W(N_W)) u_cfg (
    .clk      (clk_in),
    .take     (hold || boundary),
    .pair_in  (pair_e'(pair_sel)),
    .a_in     (swallow_val),
    .n_in     (main_val),
    .pair_eff (pair_eff),
    .cfg_err  (cfg_err)
  );

  swd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .hold      (hold),
    .pair      (pair_eff),
    .long_next (long_next),
    .tick      (tick)
  );

  swd_cycle_ctl #(.A_W(A_W), .N_W(N_W)) u_ctl (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .hold      (hold),
    .tick      (tick),
    .a_in      (swallow_val),
    .n_in      (main_val),
    .long_next (long_next),
    .boundary  (boundary),
    .fp        (fb_pulse)
  );
endmodule

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;
  logic        clk_in = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_n = 1'b1;
  logic [6:0]  swallow_val = '0;
  logic [10:0] main_val = 11'd3;
  logic        pair_sel = 1'b0;
  logic        fb_pulse, cfg_err;

  int checks = 0;
  int fails = 0;
  localparam int LIMIT = 70000;

  always #2 clk_in = ~clk_in;

  swallow_divider u0 (
    .clk_in(clk_in), .rst_n(rst_n), .run_n(run_n),
    .swallow_val(swallow_val), .main_val(main_val), .pair_sel(pair_sel),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int ratio(input int a, input int n, input logic sel);
    return n * (sel ? 64 : 32) + a;
  endfunction

  // Counts rising edges until fb_pulse is seen high, sampled 1 ns after edges.
  task automatic count_to_fp(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk_in); #1;
      cnt++;
    end while (!fb_pulse && cnt < LIMIT);
  endtask

  task automatic restart(input int a, input int n, input logic sel);
    @(negedge clk_in);
    run_n = 1'b0;
    swallow_val = 7'(a); main_val = 11'(n); pair_sel = sel;
    @(negedge clk_in); @(negedge clk_in);
    run_n = 1'b1;
  endtask

  task automatic t_reset;
    int c;
    swallow_val = 7'd5; main_val = 11'd10; pair_sel = 1'b0;
    repeat (3) @(negedge clk_in);
    check("R1 pulse low in reset", int'(fb_pulse), 0);
    rst_n = 1'b1;
    count_to_fp(c);
    check("R1 first pulse after reset", c, ratio(5, 10, 0));
  endtask

  task automatic t_ratio32;
    int c;
    restart(5, 10, 0);
    count_to_fp(c);
    check("R6 first pulse after restart", c, ratio(5, 10, 0));
    @(posedge clk_in); #1;
    check("R7 pulse one cycle wide", int'(fb_pulse), 0);
    count_to_fp(c);
    check("R2 interval pair 32/33", c + 1, ratio(5, 10, 0));
    count_to_fp(c);
    check("R2 repeated interval", c, ratio(5, 10, 0));
  endtask

  task automatic t_ratio64;
    int c;
    restart(7, 9, 1);
    count_to_fp(c);
    count_to_fp(c);
    check("R3 interval pair 64/65", c, ratio(7, 9, 1));
  endtask

  task automatic t_swallow_edges;
    int c;
    restart(0, 4, 0);
    count_to_fp(c);
    count_to_fp(c);
    check("R4 no swallow gives N*P", c, 128);
    restart(3, 3, 1);
    count_to_fp(c);
    count_to_fp(c);
    check("R4 A equal N gives N*(P+1)", c, 195);
  endtask

  task automatic t_power_save;
    int c, seen;
    restart(2, 4, 0);
    repeat (40) @(posedge clk_in);
    @(negedge clk_in);
    run_n = 1'b0;
    seen = 0;
    repeat (400) begin
      @(posedge clk_in); #1;
      if (fb_pulse) seen++;
    end
    check("R5 no pulse during power save", seen, 0);
    @(negedge clk_in);
    run_n = 1'b1;
    count_to_fp(c);
    check("R6 restart after power save", c, ratio(2, 4, 0));
  endtask

  task automatic t_mid_change;
    int c;
    restart(2, 5, 0);
    count_to_fp(c);
    repeat (10) @(posedge clk_in);
    #1;
    swallow_val = 7'd1; main_val = 11'd4; pair_sel = 1'b1;
    count_to_fp(c);
    check("R8 running cycle keeps old values", c + 10, ratio(2, 5, 0));
    count_to_fp(c);
    check("R8 new values from next boundary", c, ratio(1, 4, 1));
  endtask

  task automatic t_cfg_err;
    @(negedge clk_in);
    swallow_val = 7'd9; main_val = 11'd4;
    #1;
    check("R9 error when A > N", int'(cfg_err), 1);
    swallow_val = 7'd4;
    #1;
    check("R9 no error when A == N", int'(cfg_err), 0);
    swallow_val = 7'd127; main_val = 11'd2047;
    #1;
    check("R9 no error at extremes", int'(cfg_err), 0);
  endtask

  task automatic t_extremes;
    int c;
    restart(0, 3, 0);
    count_to_fp(c);
    check("R10 smallest main count", c, 96);
    restart(127, 2047, 0);
    count_to_fp(c);
    check("R10 largest counts", c, 65631);
  endtask

  initial begin
    t_reset();
    t_ratio32();
    t_ratio64();
    t_swallow_edges();
    t_power_save();
    t_mid_change();
    t_cfg_err();
    t_extremes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_in);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule